// File: doc/BRIEF.md
# Interrupt Controller Register Interface

This block is the memory-mapped front end of a vectored interrupt controller. A processor-side bus issues single-word reads and writes with a 12-bit byte offset. The block decodes each access and answers one cycle later with read data and an error flag. Writes are turned into one-cycle strobes toward the per-vector state storage that lives outside this block: enable set and clear masks, pending set and clear masks, and byte-lane priority writes. The only state the block keeps itself is the 3-bit priority grouping field.

Vectors 0 to 15 are the system exceptions and vectors 16 and up are the external lines. Most of the map has one bit per vector, with separate set and clear windows that both read back the live state. The external priorities have one byte per vector, and so do the configurable system handlers. Three single registers complete the map: a software trigger that pends an external line by number, a control/state word for the system exceptions, and a keyed grouping register. Unprivileged code is refused everywhere except at the trigger register, and only when a configuration bit allows it.

Top module: `intc_reg_if`

## Requirements
- R1: A write to word k of the enable-set window (byte offset 0x100 + 4k, k = 0..15) or the enable-clear window (0x180 + 4k) raises `en_set_o` or `en_clr_o` for vector 16 + 32k + b for every write-data bit b that is 1. Bits that are 0 have no effect, and vectors at or above the implemented count are never strobed.
- R2: The pending-set window (0x200 + 4k) and the pending-clear window (0x280 + 4k) drive `pend_set_o` and `pend_clr_o` with the same bit mapping as R1.
- R3: A read of word k in any of the enable, pending or active windows (active at 0x300 + 4k) returns bit b = state of vector 16 + 32k + b. Both the set and the clear aliases show the same live state, and bits for unimplemented vectors read 0.
- R4: Writes to the active window complete without error and produce no strobe of any kind.
- R5: Word k of the external priority window (0x400 + 4k, k = 0..123) maps byte j (bits 8j+7:8j) to vector 16 + 4k + j. A read returns those bytes, with 0 for unimplemented vectors. A write raises `prio_we_o` for each implemented vector in the word, with its byte at `prio_wdata_o[8v+7:8v]`.
- R6: Word k of the system handler priority window (0xD18 + 4k, k = 0..2) behaves as R5 for vector 4 + 4k + j.
- R7: A write to 0xF00 pends vector (write-data bits 8:0) + 16 through `pend_set_o` if that vector is implemented. Upper data bits are ignored, and an unimplemented number produces no strobe.
- R8: In a write to the control/state word at 0xD04, bit 31 pends vector 2. Bit 28 pends vector 14, and bit 27 clears it only when bit 28 is 0. Bits 26 and 25 act the same way on vector 15. No other bit has an effect.
- R9: A read of 0xD04 returns the current exception number in bits 8:0 and the pending vector in bits 20:12. Bit 11 is 1 when at most one of vectors 1 and up is active. Bit 22 is 1 when any external vector is pending. Bits 26, 28 and 31 report the pending state of vectors 15, 14 and 2. All other bits read 0.
- R10: A write to 0xD0C loads the grouping field from bits 10:8 only when bits 31:16 equal 0x05FA. A read returns 0xFA05 in bits 31:16, the grouping field in bits 10:8, and zeros elsewhere. The field resets to 0.
- R11: A read of offset 0x004 returns (external vector count / 32) − 1.
- R12: An unprivileged access gets an error response, read data 0 and no effect. The only exception is a write or read at 0xF00 while `user_set_pend` is 1.
- R13: Undecoded or non-word-aligned offsets read as 0, ignore writes and give an error response.
- R14: Every request gets its response (`rsp_valid`, data, error) and its strobes exactly one cycle later. Strobes last a single cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_user | input | 1 | Access comes from unprivileged code |
| bus_addr | input | 12 | Byte offset of the word accessed |
| bus_wdata | input | 32 | Write data |
| user_set_pend | input | 1 | Allows unprivileged access to the trigger register |
| vec_enabled | input | NUM_EXT+16 | Live enable bit per vector |
| vec_pending | input | NUM_EXT+16 | Live pending bit per vector |
| vec_active | input | NUM_EXT+16 | Live active bit per vector |
| vec_prio | input | 8*(NUM_EXT+16) | Priority byte per vector, vector v at bits 8v+7:8v |
| cur_exc | input | 9 | Number of the exception now executing |
| pend_vec | input | 9 | Number of the highest-priority pending vector |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_rdata | output | 32 | Read data |
| rsp_error | output | 1 | Bus error response |
| en_set_o | output | NUM_EXT+16 | One-cycle enable-set strobes |
| en_clr_o | output | NUM_EXT+16 | One-cycle enable-clear strobes |
| pend_set_o | output | NUM_EXT+16 | One-cycle pending-set strobes |
| pend_clr_o | output | NUM_EXT+16 | One-cycle pending-clear strobes |
| prio_we_o | output | NUM_EXT+16 | One-cycle priority byte write enables |
| prio_wdata_o | output | 8*(NUM_EXT+16) | Priority byte per vector for `prio_we_o` |
| prio_group_o | output | 3 | Priority grouping field |

## Verification
The assertions assume at most one request per cycle, with every input stable from the falling edge to the sampling edge. They also assume that the trigger register is the only offset an unprivileged access may reach. The bench drives every request at the falling edge, holds it for one rising edge and then drops `bus_valid`, so no two requests overlap. Its privilege cases use 0xF00 for the one permitted unprivileged path, and they use other offsets only where an error is expected. The state inputs are set between requests and never change while a request is open.

// File: rtl/intc_regs_pkg.sv
package intc_regs_pkg;

    localparam int FIRST_EXT   = 16;
    localparam int BANK_WORDS  = 16;
    localparam int PAD_VEC     = FIRST_EXT + 32 * BANK_WORDS;

    localparam int VEC_NMI     = 2;
    localparam int VEC_PENDSV  = 14;
    localparam int VEC_SYSTICK = 15;

    localparam logic [15:0] GROUP_WR_KEY = 16'h05FA;
    localparam logic [15:0] GROUP_RD_KEY = 16'hFA05;

    localparam int CS_RETBASE  = 11;
    localparam int CS_ISRPEND  = 22;
    localparam int CS_TICKPEND = 26;
    localparam int CS_SVPEND   = 28;
    localparam int CS_NMIPEND  = 31;
    localparam int CS_TICKCLR  = 25;
    localparam int CS_SVCLR    = 27;

    typedef enum logic [3:0] {
        REG_NONE, REG_TYPE, REG_EN_SET, REG_EN_CLR, REG_PD_SET, REG_PD_CLR,
        REG_ACT, REG_PRIO, REG_CTRL, REG_GROUP, REG_SYSPRIO, REG_TRIG
    } reg_sel_e;

    typedef struct packed {
        reg_sel_e   sel;
        logic [9:0] bit_base;
        logic [9:0] byte_vec;
    } reg_loc_t;

    typedef struct packed {
        reg_loc_t loc;
        logic     priv_ok;
    } reg_dec_t;

    function automatic reg_dec_t decode_addr(input logic [11:0] addr,
                                             input logic user,
                                             input logic user_trig_ok);
        reg_dec_t   d;
        logic [9:0] w;
        logic [6:0] word;
        w    = addr[11:2];
        word = '0;
        d    = '0;
        d.loc.sel = REG_NONE;
        if (addr[1:0] == 2'b00) begin
            if (w == 10'h001) begin
                d.loc.sel = REG_TYPE;
            end else if (w[9:4] == 6'h04) begin
                d.loc.sel = REG_EN_SET;  word = {3'b000, w[3:0]};
            end else if (w[9:4] == 6'h06) begin
                d.loc.sel = REG_EN_CLR;  word = {3'b000, w[3:0]};
            end else if (w[9:4] == 6'h08) begin
                d.loc.sel = REG_PD_SET;  word = {3'b000, w[3:0]};
            end else if (w[9:4] == 6'h0A) begin
                d.loc.sel = REG_PD_CLR;  word = {3'b000, w[3:0]};
            end else if (w[9:4] == 6'h0C) begin
                d.loc.sel = REG_ACT;     word = {3'b000, w[3:0]};
            end else if (w >= 10'h100 && w <= 10'h17B) begin
                d.loc.sel = REG_PRIO;    word = w[6:0];
            end else if (w == 10'h341) begin
                d.loc.sel = REG_CTRL;
            end else if (w == 10'h343) begin
                d.loc.sel = REG_GROUP;
            end else if (w >= 10'h346 && w <= 10'h348) begin
                d.loc.sel = REG_SYSPRIO; word = {5'b00000, 2'(w - 10'h346)};
            end else if (w == 10'h3C0) begin
                d.loc.sel = REG_TRIG;
            end
        end
        d.loc.bit_base = 10'(FIRST_EXT) + {1'b0, word[3:0], 5'b00000};
        d.loc.byte_vec = (d.loc.sel == REG_SYSPRIO) ? 10'd4 + {1'b0, word, 2'b00}
                                                    : 10'(FIRST_EXT) + {1'b0, word, 2'b00};
        d.priv_ok = !user || (d.loc.sel == REG_TRIG && user_trig_ok);
        return d;
    endfunction

endpackage

// File: rtl/intc_addr_decode.sv
module intc_addr_decode
    import intc_regs_pkg::*;
(
    input  logic [11:0] addr,
    input  logic        user,
    input  logic        user_trig_ok,
    output reg_dec_t    dec
);
    assign dec = decode_addr(addr, user, user_trig_ok);
endmodule

// File: rtl/intc_read_mux.sv
module intc_read_mux
    import intc_regs_pkg::*;
#(
    parameter int NUM_EXT = 64
) (
    input  reg_loc_t                          loc,
    input  logic [NUM_EXT+FIRST_EXT-1:0]      vec_enabled,
    input  logic [NUM_EXT+FIRST_EXT-1:0]      vec_pending,
    input  logic [NUM_EXT+FIRST_EXT-1:0]      vec_active,
    input  logic [8*(NUM_EXT+FIRST_EXT)-1:0]  vec_prio,
    input  logic [8:0]                        cur_exc,
    input  logic [8:0]                        pend_vec,
    input  logic [2:0]                        prio_group,
    output logic [31:0]                       rdata
);
    localparam int NUM_VEC = NUM_EXT + FIRST_EXT;
    localparam logic [31:0] TYPE_VAL = 32'((NUM_EXT / 32) - 1);

    logic [PAD_VEC-1:0]   en_p, pd_p, ac_p;
    logic [PAD_VEC*8-1:0] pr_p;
    logic [12:0]          pbit;
    logic                 ret_base, isr_pend;
    logic [31:0]          ctrl_word;

    assign en_p = PAD_VEC'(vec_enabled);
    assign pd_p = PAD_VEC'(vec_pending);
    assign ac_p = PAD_VEC'(vec_active);
    assign pr_p = (PAD_VEC * 8)'(vec_prio);
    assign pbit = {loc.byte_vec, 3'b000};

    assign ret_base = ($countones(vec_active[NUM_VEC-1:1]) <= 1);
    assign isr_pend = |vec_pending[NUM_VEC-1:FIRST_EXT];

    always_comb begin
        ctrl_word              = '0;
        ctrl_word[8:0]         = cur_exc;
        ctrl_word[CS_RETBASE]  = ret_base;
        ctrl_word[20:12]       = pend_vec;
        ctrl_word[CS_ISRPEND]  = isr_pend;
        ctrl_word[CS_TICKPEND] = vec_pending[VEC_SYSTICK];
        ctrl_word[CS_SVPEND]   = vec_pending[VEC_PENDSV];
        ctrl_word[CS_NMIPEND]  = vec_pending[VEC_NMI];
    end

    always_comb begin
        unique case (loc.sel)
            REG_TYPE:                rdata = TYPE_VAL;
            REG_EN_SET, REG_EN_CLR:  rdata = en_p[loc.bit_base +: 32];
            REG_PD_SET, REG_PD_CLR:  rdata = pd_p[loc.bit_base +: 32];
            REG_ACT:                 rdata = ac_p[loc.bit_base +: 32];
            REG_PRIO, REG_SYSPRIO:   rdata = pr_p[pbit +: 32];
            REG_CTRL:                rdata = ctrl_word;
            REG_GROUP:               rdata = {GROUP_RD_KEY, 5'b00000, prio_group, 8'h00};
            default:                 rdata = '0;
        endcase
    end
endmodule

// File: rtl/intc_write_strobes.sv
module intc_write_strobes
    import intc_regs_pkg::*;
#(
    parameter int NUM_EXT = 64
) (
    input  reg_loc_t                          loc,
    input  logic [31:0]                       wdata,
    output logic [NUM_EXT+FIRST_EXT-1:0]      en_set,
    output logic [NUM_EXT+FIRST_EXT-1:0]      en_clr,
    output logic [NUM_EXT+FIRST_EXT-1:0]      pd_set,
    output logic [NUM_EXT+FIRST_EXT-1:0]      pd_clr,
    output logic [NUM_EXT+FIRST_EXT-1:0]      prio_we,
    output logic [8*(NUM_EXT+FIRST_EXT)-1:0]  prio_wdata,
    output logic                              group_we,
    output logic [2:0]                        group_val
);
    localparam int NUM_VEC = NUM_EXT + FIRST_EXT;

    logic [NUM_VEC-1:0]   bank_bits, byte_mask, trig_hot;
    logic [NUM_VEC*8-1:0] byte_data;
    logic [9:0]           trig_vec;

    assign bank_bits = NUM_VEC'(PAD_VEC'(wdata) << loc.bit_base);
    assign byte_mask = NUM_VEC'(PAD_VEC'(4'hF) << loc.byte_vec);
    assign byte_data = (NUM_VEC * 8)'((PAD_VEC * 8)'(wdata) << {loc.byte_vec, 3'b000});
    assign trig_vec  = 10'(wdata[8:0]) + 10'(FIRST_EXT);
    assign trig_hot  = NUM_VEC'(PAD_VEC'(1'b1) << trig_vec);

    always_comb begin
        en_set     = '0;
        en_clr     = '0;
        pd_set     = '0;
        pd_clr     = '0;
        prio_we    = '0;
        prio_wdata = byte_data;
        group_we   = 1'b0;
        group_val  = wdata[10:8];
        unique case (loc.sel)
            REG_EN_SET:  en_set = bank_bits;
            REG_EN_CLR:  en_clr = bank_bits;
            REG_PD_SET:  pd_set = bank_bits;
            REG_PD_CLR:  pd_clr = bank_bits;
            REG_PRIO, REG_SYSPRIO: prio_we = byte_mask;
            REG_TRIG:    pd_set = trig_hot;
            REG_CTRL: begin
                pd_set[VEC_NMI]     = wdata[CS_NMIPEND];
                pd_set[VEC_PENDSV]  = wdata[CS_SVPEND];
                pd_clr[VEC_PENDSV]  = !wdata[CS_SVPEND] && wdata[CS_SVCLR];
                pd_set[VEC_SYSTICK] = wdata[CS_TICKPEND];
                pd_clr[VEC_SYSTICK] = !wdata[CS_TICKPEND] && wdata[CS_TICKCLR];
            end
            REG_GROUP:   group_we = (wdata[31:16] == GROUP_WR_KEY);
            default: ;
        endcase
    end
endmodule

// File: rtl/intc_reg_if.sv
module intc_reg_if
    import intc_regs_pkg::*;
#(
    parameter int NUM_EXT = 64
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              bus_valid,
    input  logic                              bus_write,
    input  logic                              bus_user,
    input  logic [11:0]                       bus_addr,
    input  logic [31:0]                       bus_wdata,
    input  logic                              user_set_pend,
    input  logic [NUM_EXT+16-1:0]             vec_enabled,
    input  logic [NUM_EXT+16-1:0]             vec_pending,
    input  logic [NUM_EXT+16-1:0]             vec_active,
    input  logic [8*(NUM_EXT+16)-1:0]         vec_prio,
    input  logic [8:0]                        cur_exc,
    input  logic [8:0]                        pend_vec,
    output logic                              rsp_valid,
    output logic [31:0]                       rsp_rdata,
    output logic                              rsp_error,
    output logic [NUM_EXT+16-1:0]             en_set_o,
    output logic [NUM_EXT+16-1:0]             en_clr_o,
    output logic [NUM_EXT+16-1:0]             pend_set_o,
    output logic [NUM_EXT+16-1:0]             pend_clr_o,
    output logic [NUM_EXT+16-1:0]             prio_we_o,
    output logic [8*(NUM_EXT+16)-1:0]         prio_wdata_o,
    output logic [2:0]                        prio_group_o
);
    localparam int NUM_VEC = NUM_EXT + FIRST_EXT;

    reg_dec_t             dec;
    logic [31:0]          rd_word;
    logic [NUM_VEC-1:0]   s_en_set, s_en_clr, s_pd_set, s_pd_clr, s_prio_we;
    logic [NUM_VEC*8-1:0] s_prio_data;
    logic                 s_group_we;
    logic [2:0]           s_group_val;
    logic                 access_ok, do_write, do_read;

    intc_addr_decode u_decode (
        .addr         (bus_addr),
        .user         (bus_user),
        .user_trig_ok (user_set_pend),
        .dec          (dec)
    );

    intc_read_mux #(.NUM_EXT(NUM_EXT)) u_read (
        .loc         (dec.loc),
        .vec_enabled (vec_enabled),
        .vec_pending (vec_pending),
        .vec_active  (vec_active),
        .vec_prio    (vec_prio),
        .cur_exc     (cur_exc),
        .pend_vec    (pend_vec),
        .prio_group  (prio_group_o),
        .rdata       (rd_word)
    );

    intc_write_strobes #(.NUM_EXT(NUM_EXT)) u_write (
        .loc        (dec.loc),
        .wdata      (bus_wdata),
        .en_set     (s_en_set),
        .en_clr     (s_en_clr),
        .pd_set     (s_pd_set),
        .pd_clr     (s_pd_clr),
        .prio_we    (s_prio_we),
        .prio_wdata (s_prio_data),
        .group_we   (s_group_we),
        .group_val  (s_group_val)
    );

    assign access_ok = bus_valid && (dec.loc.sel != REG_NONE) && dec.priv_ok;
    assign do_write  = access_ok && bus_write;
    assign do_read   = access_ok && !bus_write;

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid    <= 1'b0;
            rsp_rdata    <= '0;
            rsp_error    <= 1'b0;
            en_set_o     <= '0;
            en_clr_o     <= '0;
            pend_set_o   <= '0;
            pend_clr_o   <= '0;
            prio_we_o    <= '0;
            prio_wdata_o <= '0;
            prio_group_o <= '0;
        end else begin
            rsp_valid    <= bus_valid;
            rsp_error    <= bus_valid && !access_ok;
            rsp_rdata    <= do_read  ? rd_word   : '0;
            en_set_o     <= do_write ? s_en_set  : '0;
            en_clr_o     <= do_write ? s_en_clr  : '0;
            pend_set_o   <= do_write ? s_pd_set  : '0;
            pend_clr_o   <= do_write ? s_pd_clr  : '0;
            prio_we_o    <= do_write ? s_prio_we : '0;
            prio_wdata_o <= s_prio_data;
            if (do_write && s_group_we) begin
                prio_group_o <= s_group_val;
            end
        end
    end

    logic any_strobe;
    assign any_strobe = |{en_set_o, en_clr_o, pend_set_o, pend_clr_o, prio_we_o};

    assert_resp_follows_R14: assert property (@(posedge clk) disable iff (rst)
        bus_valid |=> rsp_valid);

    assert_strobe_needs_resp_R14: assert property (@(posedge clk) disable iff (rst)
        any_strobe |-> rsp_valid);

    assert_user_fault_R12: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && bus_user && bus_addr != 12'hF00) |=> rsp_error);

    assert_err_quiet_R13: assert property (@(posedge clk) disable iff (rst)
        rsp_error |-> (!any_strobe && rsp_rdata == '0));

    assert_ctrl_exclusive_R8: assert property (@(posedge clk) disable iff (rst)
        !(|(pend_set_o & pend_clr_o)));

    assert_group_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !(bus_valid && bus_write) |=> $stable(prio_group_o));

endmodule

// File: tb/test_intc_reg_if.sv
module test_intc_reg_if;
    localparam int NE = 64;
    localparam int NV = NE + 16;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic               rst;
    logic               bus_valid, bus_write, bus_user;
    logic [11:0]        bus_addr;
    logic [31:0]        bus_wdata;
    logic               user_set_pend;
    logic [NV-1:0]      en_s, pd_s, ac_s;
    logic [NV*8-1:0]    pr_s;
    logic [8:0]         cur_exc, pend_vec;
    logic               rsp_valid, rsp_error;
    logic [31:0]        rsp_rdata;
    logic [NV-1:0]      en_set_o, en_clr_o, pend_set_o, pend_clr_o, prio_we_o;
    logic [NV*8-1:0]    prio_wdata_o;
    logic [2:0]         prio_group_o;

    intc_reg_if #(.NUM_EXT(NE)) i_intc_reg_if (
        .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_user(bus_user), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .user_set_pend(user_set_pend), .vec_enabled(en_s), .vec_pending(pd_s),
        .vec_active(ac_s), .vec_prio(pr_s), .cur_exc(cur_exc), .pend_vec(pend_vec),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_error(rsp_error),
        .en_set_o(en_set_o), .en_clr_o(en_clr_o), .pend_set_o(pend_set_o),
        .pend_clr_o(pend_clr_o), .prio_we_o(prio_we_o), .prio_wdata_o(prio_wdata_o),
        .prio_group_o(prio_group_o)
    );

    int checks = 0;
    int fails  = 0;

    logic            r_valid, r_err;
    logic [31:0]     r_data;
    logic [NV-1:0]   s_es, s_ec, s_ps, s_pc, s_pm;
    logic [NV*8-1:0] s_pd;
    logic [NV-1:0]   e_es, e_ec, e_ps, e_pc, e_pm;

    task automatic chk(input string req, input logic [639:0] act, input logic [639:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic access(input logic wr, input logic usr, input logic [11:0] a,
                          input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = wr; bus_user = usr; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #1;
        r_valid = rsp_valid; r_err = rsp_error; r_data = rsp_rdata;
        s_es = en_set_o; s_ec = en_clr_o; s_ps = pend_set_o; s_pc = pend_clr_o;
        s_pm = prio_we_o; s_pd = prio_wdata_o;
        bus_valid = 1'b0;
    endtask

    task automatic clr_exp();
        e_es = '0; e_ec = '0; e_ps = '0; e_pc = '0; e_pm = '0;
    endtask

    task automatic chk_strobes(input string req);
        chk(req, 640'({s_es, s_ec, s_ps, s_pc, s_pm}), 640'({e_es, e_ec, e_ps, e_pc, e_pm}));
    endtask

    function automatic logic [31:0] bank_exp(input logic [NV-1:0] arr, input int k);
        logic [31:0] r = '0;
        for (int b = 0; b < 32; b++) begin
            if (16 + 32 * k + b < NV) r[b] = arr[16 + 32 * k + b];
        end
        return r;
    endfunction

    function automatic logic [31:0] prio_exp(input int first);
        logic [31:0] r = '0;
        for (int j = 0; j < 4; j++) begin
            if (first + j < NV) r[8*j +: 8] = pr_s[(first + j) * 8 +: 8];
        end
        return r;
    endfunction

    function automatic logic [31:0] ctrl_exp();
        logic [31:0] r = '0;
        int n = 0;
        logic ext = 1'b0;
        for (int v = 1; v < NV; v++) n += int'(ac_s[v]);
        for (int v = 16; v < NV; v++) ext |= pd_s[v];
        r[8:0] = cur_exc; r[20:12] = pend_vec;
        r[11] = (n <= 1); r[22] = ext;
        r[26] = pd_s[15]; r[28] = pd_s[14]; r[31] = pd_s[2];
        return r;
    endfunction

    task automatic prio_write(input string req, input logic [11:0] a, input int first,
                              input logic [31:0] wd);
        logic [NV*8-1:0] md = '0;
        logic [NV*8-1:0] ed = '0;
        access(1'b1, 1'b0, a, wd);
        clr_exp();
        for (int j = 0; j < 4; j++) begin
            if (first + j < NV) begin
                e_pm[first + j] = 1'b1;
                ed[(first + j) * 8 +: 8] = wd[8*j +: 8];
            end
        end
        for (int v = 0; v < NV; v++) if (s_pm[v]) md[v*8 +: 8] = s_pd[v*8 +: 8];
        chk_strobes(req);
        chk(req, 640'(md), 640'(ed));
    endtask

    initial begin
        #1_000_000;
        checks++; fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        logic [11:0] bases [5];
        rst = 1'b1; bus_valid = 1'b0; bus_write = 1'b0; bus_user = 1'b0;
        bus_addr = '0; bus_wdata = '0; user_set_pend = 1'b0;
        cur_exc = '0; pend_vec = '0;
        for (int v = 0; v < NV; v++) begin
            en_s[v] = ((v * 5) % 7) < 3;
            pd_s[v] = (v % 3) == 1;
            ac_s[v] = (v % 4) == 0;
            pr_s[v*8 +: 8] = 8'((v * 37 + 11) & 255);
        end
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        #1;
        // R14 / R10 reset state
        chk("R14 reset outputs", 640'({rsp_valid, rsp_error, rsp_rdata, en_set_o, pend_set_o, prio_we_o}), 640'(0));
        chk("R10 reset group", 640'(prio_group_o), 640'(0));

        bases[0] = 12'h100; bases[1] = 12'h180; bases[2] = 12'h200;
        bases[3] = 12'h280; bases[4] = 12'h300;

        // R1 / R2: write sweep over every word of the four bit banks
        for (int bk = 0; bk < 4; bk++) begin
            for (int k = 0; k < 16; k++) begin
                logic [31:0] wd;
                wd = 32'h9E37_79B9 ^ (32'h0101_0101 * 32'(k)) ^ 32'(bk);
                access(1'b1, 1'b0, bases[bk] + 12'(4 * k), wd);
                clr_exp();
                for (int v = 16; v < NV; v++) begin
                    if ((v - 16) / 32 == k && wd[(v - 16) % 32]) begin
                        case (bk)
                            0: e_es[v] = 1'b1;
                            1: e_ec[v] = 1'b1;
                            2: e_ps[v] = 1'b1;
                            default: e_pc[v] = 1'b1;
                        endcase
                    end
                end
                chk(bk < 2 ? "R1 enable bank strobes" : "R2 pending bank strobes",
                    640'({s_es, s_ec, s_ps, s_pc, s_pm, r_err, r_valid}),
                    640'({e_es, e_ec, e_ps, e_pc, e_pm, 1'b0, 1'b1}));
            end
        end

        // R3: read sweep over all bit-bank windows
        for (int bk = 0; bk < 5; bk++) begin
            for (int k = 0; k < 16; k++) begin
                logic [31:0] ex;
                access(1'b0, 1'b0, bases[bk] + 12'(4 * k), 32'h0);
                ex = (bk < 2) ? bank_exp(en_s, k) : (bk < 4) ? bank_exp(pd_s, k) : bank_exp(ac_s, k);
                chk("R3 bit bank read", 640'({r_err, r_data}), 640'({1'b0, ex}));
            end
        end

        // R4: active window ignores writes
        access(1'b1, 1'b0, 12'h300, 32'hFFFF_FFFF);
        clr_exp();
        chk_strobes("R4 active write strobes");
        chk("R4 active write response", 640'({r_valid, r_err}), 640'({1'b1, 1'b0}));

        // R5: external priority reads and writes
        for (int k = 0; k < 124; k++) begin
            access(1'b0, 1'b0, 12'h400 + 12'(4 * k), 32'h0);
            chk("R5 priority read", 640'({r_err, r_data}), 640'({1'b0, prio_exp(16 + 4 * k)}));
        end
        for (int k = 0; k < 22; k++) begin
            int kk;
            kk = (k < 20) ? k : (k == 20 ? 30 : 123);
            prio_write("R5 priority write", 12'h400 + 12'(4 * kk), 16 + 4 * kk,
                       32'h1357_9BDF ^ (32'h0011_2233 * 32'(kk)));
        end

        // R6: system handler priorities
        for (int k = 0; k < 3; k++) begin
            access(1'b0, 1'b0, 12'hD18 + 12'(4 * k), 32'h0);
            chk("R6 system priority read", 640'({r_err, r_data}), 640'({1'b0, prio_exp(4 + 4 * k)}));
            prio_write("R6 system priority write", 12'hD18 + 12'(4 * k), 4 + 4 * k,
                       32'hA1B2_C3D4 + 32'(k));
        end

        // R7: software trigger sweep, junk in upper bits
        for (int n = 0; n < 72; n++) begin
            access(1'b1, 1'b0, 12'hF00, 32'hDEAD_BE00 & 32'hFFFF_FE00 | 32'(n));
            clr_exp();
            if (n + 16 < NV) e_ps[n + 16] = 1'b1;
            chk_strobes("R7 trigger strobe");
        end
        access(1'b1, 1'b0, 12'hF00, 32'h0000_01FF);
        clr_exp();
        chk_strobes("R7 trigger out of range");

        // R8: every combination of the control write bits
        for (int c = 0; c < 32; c++) begin
            logic [31:0] wd;
            wd = 32'h00F0_F0F0;
            wd[31] = c[4]; wd[28] = c[3]; wd[27] = c[2]; wd[26] = c[1]; wd[25] = c[0];
            access(1'b1, 1'b0, 12'hD04, wd);
            clr_exp();
            e_ps[2] = c[4];
            e_ps[14] = c[3]; e_pc[14] = !c[3] && c[2];
            e_ps[15] = c[1]; e_pc[15] = !c[1] && c[0];
            chk_strobes("R8 control write");
        end

        // R9: control read under several state patterns
        for (int sc = 0; sc < 4; sc++) begin
            cur_exc = 9'(sc * 77 + 3);
            pend_vec = 9'(sc * 131 + 17);
            if (sc == 1) begin ac_s = '0; pd_s = '0; pd_s[14] = 1'b1; pd_s[2] = 1'b1; end
            if (sc == 2) begin ac_s = '0; ac_s[40] = 1'b1; pd_s = '0; pd_s[15] = 1'b1; pd_s[79] = 1'b1; end
            if (sc == 3) begin ac_s = '0; ac_s[0] = 1'b1; ac_s[5] = 1'b1; pd_s = '0; end
            access(1'b0, 1'b0, 12'hD04, 32'h0);
            chk("R9 control read", 640'({r_err, r_data}), 640'({1'b0, ctrl_exp()}));
        end
        ac_s = '0; ac_s[5] = 1'b1; ac_s[6] = 1'b1;
        access(1'b0, 1'b0, 12'hD04, 32'h0);
        chk("R9 control read two active", 640'(r_data), 640'(ctrl_exp()));

        // R10: keyed grouping field
        access(1'b0, 1'b0, 12'hD0C, 32'h0);
        chk("R10 group initial read", 640'(r_data), 640'(32'hFA05_0000));
        access(1'b1, 1'b0, 12'hD0C, 32'h05FA_0500);
        access(1'b0, 1'b0, 12'hD0C, 32'h0);
        chk("R10 group keyed write", 640'({r_data, prio_group_o}), 640'({32'hFA05_0500, 3'd5}));
        access(1'b1, 1'b0, 12'hD0C, 32'h05FB_0200);
        access(1'b0, 1'b0, 12'hD0C, 32'h0);
        chk("R10 group bad key ignored", 640'(r_data), 640'(32'hFA05_0500));
        access(1'b1, 1'b0, 12'hD0C, 32'h05FA_FFFF);
        access(1'b0, 1'b0, 12'hD0C, 32'h0);
        chk("R10 group other bits", 640'(r_data), 640'(32'hFA05_0700));

        // R11: type word
        access(1'b0, 1'b0, 12'h004, 32'h0);
        chk("R11 type read", 640'({r_err, r_data}), 640'({1'b0, 32'(NE / 32 - 1)}));

        // R12: privilege
        access(1'b0, 1'b1, 12'h100, 32'h0);
        chk("R12 user read", 640'({r_err, r_data}), 640'({1'b1, 32'h0}));
        access(1'b1, 1'b1, 12'h200, 32'hFFFF_FFFF);
        clr_exp();
        chk_strobes("R12 user write strobes");
        chk("R12 user write error", 640'(r_err), 640'(1));
        access(1'b1, 1'b1, 12'hD0C, 32'h05FA_0100);
        access(1'b0, 1'b0, 12'hD0C, 32'h0);
        chk("R12 user group write ignored", 640'(r_data), 640'(32'hFA05_0700));
        access(1'b1, 1'b1, 12'hF00, 32'h3);
        clr_exp();
        chk_strobes("R12 user trigger gated off");
        chk("R12 user trigger error", 640'(r_err), 640'(1));
        user_set_pend = 1'b1;
        access(1'b1, 1'b1, 12'hF00, 32'h3);
        clr_exp(); e_ps[19] = 1'b1;
        chk_strobes("R12 user trigger allowed");
        chk("R12 user trigger ok", 640'(r_err), 640'(0));
        user_set_pend = 1'b0;

        // R13: undecoded and unaligned offsets
        for (int i = 0; i < 9; i++) begin
            logic [11:0] a;
            case (i)
                0: a = 12'h000; 1: a = 12'h140; 2: a = 12'h1C0; 3: a = 12'h5F0;
                4: a = 12'hD00; 5: a = 12'hD10; 6: a = 12'hD24; 7: a = 12'hFFC;
                default: a = 12'h101;
            endcase
            access(1'b0, 1'b0, a, 32'h0);
            chk("R13 undecoded read", 640'({r_valid, r_err, r_data}), 640'({1'b1, 1'b1, 32'h0}));
            access(1'b1, 1'b0, a, 32'hFFFF_FFFF);
            clr_exp();
            chk_strobes("R13 undecoded write");
        end

        // R14: strobes last one cycle
        access(1'b1, 1'b0, 12'h100, 32'hFFFF_FFFF);
        @(posedge clk); #1;
        chk("R14 single cycle strobe", 640'({rsp_valid, en_set_o}), 640'(0));

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule